// File: doc/BRIEF.md
# Legacy Video-Processor Host Port

This block is the processor-facing side of a tile-and-sprite video processor. A host CPU reaches it over an 8-bit bus with separate active-low read and write strobes and a single mode line: mode low selects the data port, mode high selects the control/status port. Two consecutive control writes either set a 14-bit video-memory address (for reading or writing) or load one of the internal control registers. Data-port reads and writes then stream through video memory, with the address stepping by one after each access.

The host never waits for the display. Every data access is turned into exactly one operation on a single-cycle synchronous RAM a fixed number of clocks after the strobe ends. An 8-bit page register extends the 14-bit address to 22 bits, so 256 pages of 16 KB can be reached. It resets to zero, so software that knows nothing of paging sees only the first 16 KB. A free-running frame divider raises the vertical-blank interrupt at either of two programmable rates (nominally 60 Hz or 50 Hz). A status read reports the interrupt and acknowledges it.

Strobes are synchronised into the clock domain. An action takes effect on the synchronised rising edge of its strobe.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, irq_n is high, the page is 0, the address is 0, all control registers read 0, the rate select is the default (A) rate, and host_oe is low.
- R2: A control-port write pair (first byte B1, second byte B2 with B2[7:6]=01) sets the address to {B2[5:0],B1}. The next data-port write stores its byte at RAM address {page,address}.
- R3: Every data-port read or write advances the address by one. It wraps from 0x3FFF to 0x0000 and leaves the page unchanged.
- R4: A control pair with B2[7:6]=00 sets the address and fetches that byte ahead. Each data-port read returns the byte fetched ahead and then fetches the next byte.
- R5: A control pair with B2[7:6]=10 writes B1 into the register numbered B2[3:0]. Numbers 0..7 drive ctrl_regs[8n+7:8n], 8 is the page register, 9 is the rate select (bit 0: 0 = rate A, 1 = rate B), and numbers 10..15 are ignored. A pair with B2[7:6]=11 changes nothing.
- R6: Every RAM operation carries the current page in mem_addr[21:14].
- R7: The interrupt flag is set once every FRAME_A_CYC clocks with rate A selected, and once every FRAME_B_CYC clocks with rate B selected. irq_n is low while the flag is set.
- R8: A status-port read returns the flag in bit 7, with bits 6..0 zero. It clears the flag and releases irq_n.
- R9: A status read discards a pending first control byte, so the next control write is taken as a first byte.
- R10: host_oe is high exactly while host_rd_n is low.
- R11: Each data-port access issues exactly one RAM operation, on the clock after the strobe end is seen, with no wait on display activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_din | input | 8 | Bus byte from the host |
| host_dout | output | 8 | Bus byte to the host |
| host_oe | output | 1 | Bus drive enable toward the host |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_mode | input | 1 | 0 = data port, 1 = control/status port |
| irq_n | output | 1 | Active-low vertical-blank interrupt |
| mem_addr | output | 22 | RAM byte address {page, address} |
| mem_we | output | 1 | RAM write pulse |
| mem_re | output | 1 | RAM read pulse; data valid one clock later |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte |
| ctrl_regs | output | 64 | Control registers 0..7, register n in bits 8n+7..8n |

## Verification
The assertions take for granted that the two strobes never overlap, that each strobe stays low for several clocks, and that mode and data are steady for the whole strobe. They also take for granted that consecutive strobes are far enough apart for a read-ahead to land before the next read. The bench drives every access through one task that holds the strobe low for four clocks and then idles ten. It never asserts both strobes together, so every access fits these assumptions. The sweeps cover address wrap on several pages and every register number, and the interrupt periods are timed edge to edge.

// File: rtl/vdp_host_port.sv
module vdp_host_port #(
  parameter int PAGE_W      = 8,
  parameter int NREG        = 8,
  parameter int PAGE_REG    = 8,
  parameter int RATE_REG    = 9,
  parameter int FRAME_A_CYC = 1666667,
  parameter int FRAME_B_CYC = 2000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             host_din,
  output logic [7:0]             host_dout,
  output logic                   host_oe,
  input  logic                   host_rd_n,
  input  logic                   host_wr_n,
  input  logic                   host_mode,
  output logic                   irq_n,
  output logic [PAGE_W+13:0]     mem_addr,
  output logic                   mem_we,
  output logic                   mem_re,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic [8*NREG-1:0]      ctrl_regs
);
  localparam int ADDR_W  = 14;
  localparam int MA_W    = PAGE_W + ADDR_W;
  localparam int CYC_MAX = (FRAME_A_CYC > FRAME_B_CYC) ? FRAME_A_CYC : FRAME_B_CYC;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  logic [2:0]        rd_sy, wr_sy;
  logic              rd_done, wr_done, busy;
  logic              cap_mode;
  logic [7:0]        cap_data, first_b;
  logic              have_first;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] page;
  logic              rate_b;
  logic [7:0]        rdbuf;
  logic              rd_pend;
  logic              flag, stat_snap, tick, ack;
  logic [CNT_W-1:0]  fcnt, flim;
  logic [3:0]        ridx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sy <= 3'b111;
      wr_sy <= 3'b111;
    end else begin
      rd_sy <= {rd_sy[1:0], host_rd_n};
      wr_sy <= {wr_sy[1:0], host_wr_n};
    end
  end

  assign rd_done = rd_sy[1] & ~rd_sy[2];
  assign wr_done = wr_sy[1] & ~wr_sy[2];
  assign busy    = ~rd_sy[1] | ~wr_sy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_mode <= 1'b0;
      cap_data <= '0;
    end else if (busy) begin
      cap_mode <= host_mode;
      cap_data <= host_din;
    end
  end

  assign flim = rate_b ? CNT_W'(FRAME_B_CYC - 1) : CNT_W'(FRAME_A_CYC - 1);
  assign tick = fcnt >= flim;

  always_ff @(posedge clk) begin
    if (!rst_n)    fcnt <= '0;
    else if (tick) fcnt <= '0;
    else           fcnt <= fcnt + 1'b1;
  end

  assign ack = rd_done & cap_mode & stat_snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      stat_snap <= 1'b0;
    end else begin
      flag <= tick | (flag & ~ack);
      if (rd_sy[1]) stat_snap <= flag;
    end
  end

  assign irq_n     = ~flag;
  assign host_oe   = ~host_rd_n;
  assign host_dout = host_mode ? {stat_snap, 7'b0} : rdbuf;
  assign ridx      = cap_data[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      page       <= '0;
      rate_b     <= 1'b0;
      have_first <= 1'b0;
      first_b    <= '0;
      rdbuf      <= '0;
      rd_pend    <= 1'b0;
      mem_addr   <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_wdata  <= '0;
      ctrl_regs  <= '0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      rd_pend <= mem_re;
      if (rd_pend) rdbuf <= mem_rdata;

      if (rd_done) begin
        if (cap_mode) begin
          have_first <= 1'b0;
        end else begin
          mem_re   <= 1'b1;
          mem_addr <= {page, addr};
          addr     <= addr + 1'b1;
        end
      end else if (wr_done) begin
        if (!cap_mode) begin
          mem_we    <= 1'b1;
          mem_addr  <= {page, addr};
          mem_wdata <= cap_data;
          addr      <= addr + 1'b1;
        end else if (!have_first) begin
          first_b    <= cap_data;
          have_first <= 1'b1;
        end else begin
          have_first <= 1'b0;
          case (cap_data[7:6])
            2'b00: begin
              mem_re   <= 1'b1;
              mem_addr <= {page, cap_data[5:0], first_b};
              addr     <= {cap_data[5:0], first_b} + 1'b1;
            end
            2'b01: addr <= {cap_data[5:0], first_b};
            2'b10: begin
              if (int'(ridx) < NREG)          ctrl_regs[ridx*8 +: 8] <= first_b;
              else if (int'(ridx) == PAGE_REG) page   <= first_b;
              else if (int'(ridx) == RATE_REG) rate_b <= first_b[0];
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[ADDR_W-1:0] == ADDR_W'(addr - 1'b1));

  p_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[MA_W-1:ADDR_W] == page);

  p_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(fcnt) >= $past(flim));

  p_irq_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(rd_done && cap_mode));

  p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  p_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !cap_mode) |=> mem_re);

endmodule

// File: tb/sim_vdp_host_port.sv
module sim_vdp_host_port;
  localparam int PA = 300;
  localparam int PB = 360;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_din = '0;
  logic [7:0]  host_dout;
  logic        host_oe;
  logic        host_rd_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic        host_mode = 1'b0;
  logic        irq_n;
  logic [21:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [63:0] ctrl_regs;

  int nvec = 0, nbad = 0, cyc = 0, fall_t = 0;
  logic [21:0] last_we_addr = '0;
  logic [7:0]  ram [int];

  always #10 clk = ~clk;

  vdp_host_port #(.FRAME_A_CYC(PA), .FRAME_B_CYC(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .host_din(host_din), .host_dout(host_dout),
    .host_oe(host_oe), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_mode(host_mode), .irq_n(irq_n), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ctrl_regs(ctrl_regs));

  function automatic logic [7:0] pat(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b0, a[21:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      ram[int'(mem_addr)] = mem_wdata;
      last_we_addr <= mem_addr;
    end
    if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : pat(mem_addr);
  end

  always @(negedge irq_n) fall_t = cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic md, input logic [7:0] b);
    @(negedge clk);
    host_mode = md; host_din = b; host_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_rd(input logic md, output logic [7:0] b, output logic oe);
    @(negedge clk);
    host_mode = md; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    b = host_dout; oe = host_oe;
    host_rd_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] b1, input logic [7:0] b2);
    bus_wr(1'b1, b1);
    bus_wr(1'b1, b2);
  endtask

  task automatic set_page(input logic [7:0] p);
    ctl(p, 8'h88);
  endtask

  task automatic status(output logic [7:0] s);
    logic oe;
    bus_rd(1'b1, s, oe);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : main
    logic [7:0] b, s;
    logic oe;
    logic [13:0] a;
    int f1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
    chk(ctrl_regs === 64'h0, "R1 regs", int'(ctrl_regs[31:0]), 0);
    chk(host_oe === 1'b0, "R1 oe", host_oe, 0);
    bus_wr(1'b0, 8'hC3);
    chk(last_we_addr === 22'h0, "R1 addr/page zero", last_we_addr, 0);

    // R2 R3 R4 R6 R11: write and read sweeps across the wrap on several pages
    foreach (ram[k]) ram.delete(k);
    for (int pi = 0; pi < 3; pi++) begin
      logic [7:0] p;
      p = (pi == 0) ? 8'h00 : (pi == 1) ? 8'h05 : 8'hFF;
      set_page(p);
      ctl(8'hF0, 8'h7F);
      for (int i = 0; i < 32; i++) begin
        a = 14'h3FF0 + 14'(i);
        bus_wr(1'b0, 8'(i * 7) + p);
        chk(last_we_addr === {p, a}, "R2 R3 R6 write address", last_we_addr, {p, a});
      end
      ctl(8'hF0, 8'h3F);
      for (int i = 0; i < 32; i++) begin
        bus_rd(1'b0, b, oe);
        chk(b === 8'(i * 7) + p, "R4 R3 read-ahead data", b, 8'(i * 7) + p);
        chk(oe === 1'b1, "R10 oe during read", oe, 1);
      end
      chk(host_oe === 1'b0, "R10 oe idle", host_oe, 0);
    end

    // R4 unwritten location reads RAM content at prefetch address
    set_page(8'h21);
    ctl(8'h34, 8'h12);
    bus_rd(1'b0, b, oe);
    chk(b === pat({8'h21, 14'h1234}), "R4 prefetch", b, pat({8'h21, 14'h1234}));
    bus_rd(1'b0, b, oe);
    chk(b === pat({8'h21, 14'h1235}), "R4 next", b, pat({8'h21, 14'h1235}));

    // R5 register sweep
    for (int r = 0; r < 8; r++) ctl(8'(8'h11 * r + 3), 8'(8'h80 | r));
    for (int r = 0; r < 8; r++)
      chk(ctrl_regs[r*8 +: 8] === 8'(8'h11 * r + 3), "R5 reg value", ctrl_regs[r*8 +: 8], 8'(8'h11 * r + 3));
    // R5 ignored numbers and code 11
    set_page(8'h06);
    ctl(8'h00, 8'h41);
    for (int r = 10; r < 16; r++) ctl(8'hEE, 8'(8'h80 | r));
    ctl(8'h55, 8'hC2);
    bus_wr(1'b0, 8'h99);
    chk(last_we_addr === {8'h06, 14'h0100}, "R5 ignored writes", last_we_addr, {8'h06, 14'h0100});
    chk(ctrl_regs[7:0] === 8'h03, "R5 reg0 untouched", ctrl_regs[7:0], 3);

    // R9 status read resets the byte latch
    bus_wr(1'b1, 8'h12);
    status(s);
    ctl(8'h34, 8'h45);
    bus_wr(1'b0, 8'hAB);
    chk(last_we_addr === {8'h06, 14'h0534}, "R9 latch reset", last_we_addr, {8'h06, 14'h0534});

    // R7 R8 interrupt rate A
    @(negedge irq_n); @(negedge clk);
    status(s);
    chk(s === 8'h80, "R8 status set", s, 8'h80);
    chk(irq_n === 1'b1, "R8 irq released", irq_n, 1);
    status(s);
    chk(s === 8'h00, "R8 status cleared", s, 0);
    f1 = fall_t;
    @(negedge irq_n); @(negedge clk);
    chk(fall_t - f1 === PA, "R7 period A", fall_t - f1, PA);
    status(s);
    // rate B
    ctl(8'h01, 8'h89);
    @(negedge irq_n); @(negedge clk);
    status(s);
    f1 = fall_t;
    @(negedge irq_n); @(negedge clk);
    chk(fall_t - f1 === PB, "R7 period B", fall_t - f1, PB);
    status(s);
    chk(s === 8'h80 && irq_n === 1'b1, "R8 ack B", s, 8'h80);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule